// File: doc/BRIEF.md
# FIFO-Replacement Reuse Tracker

This block models a small on-chip buffer that remembers recently requested element addresses and tells, for every reference in a stream, whether that address is still held. A reference whose address is present is counted as reused and takes no new storage. A reference that is absent is stored. When every slot is occupied, the slot written longest ago is overwritten.

Lookup is fully associative. It compares the incoming address with every occupied slot in the same cycle. Replacement is strictly first-in-first-out: a hit never changes the age of any slot. Two saturating counters, one for all accepted references and one for reused references, give the reuse rate as their ratio.

The block is meant for sizing studies. An address generator replays a loop nest's reference stream into it, and software later reads the two counts.

Top module: `reuse_fifo_tracker`

## Requirements
- R1: After reset, no slot is occupied, both counters read zero and `hit_vld_o` is low.
- R2: For a request accepted at clock edge t, `hit_vld_o` is high after edge t. `hit_o` is high after edge t exactly when the address matched an occupied slot before that edge.
- R3: A request that misses stores its address. A later request to the same address hits, including a request in the very next cycle, provided the address has not been evicted in between.
- R4: When all DEPTH slots are occupied, a miss overwrites the slot filled earliest among those present. Only that address stops hitting.
- R5: A hit does not refresh an entry's age. An address that was hit is still the next one evicted if it is the oldest.
- R6: The reference counter increases by one for each accepted request. The hit counter increases by one for each accepted request that hits. Both counters change at the same edge as `hit_vld_o`.
- R7: Both counters saturate at all ones and never wrap.
- R8: `clr_i` empties every slot and zeroes both counters at the next edge. A request presented in the same cycle as `clr_i` is dropped: it is not counted, not stored, and `hit_vld_o` is low after that edge.
- R9: In a cycle with no request, `hit_vld_o` and `hit_o` are low after the edge and both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of slots and counters |
| req_vld_i | input | 1 | A reference is presented this cycle |
| req_addr_i | input | ADDR_W | Element address of the reference |
| hit_vld_o | output | 1 | The previous cycle held an accepted reference |
| hit_o | output | 1 | That reference was found in the buffer |
| hit_cnt_o | output | CNT_W | Saturating count of reused references |
| ref_cnt_o | output | CNT_W | Saturating count of accepted references |

## Verification
A clear and a request can land in the same cycle. The bench presents a stencil address together with `clr_i` in the middle of a populated run. It expects that reference to vanish: no `hit_vld_o`, both counters zero, and the next request to the same address misses. Counter saturation can also coincide with a hit. A second instance with 4-bit counters is fed the full 162-reference stream, so both counts reach their ceiling while hits keep arriving, and they must stay pinned at 15. Every cycle is compared against a queue-based model for depths 16 and 64.

// File: rtl/reuse_fifo_tracker.sv
module reuse_fifo_tracker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_vld_o,
  output logic              hit_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  ref_cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0]  live_q;
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  wr_ptr_q;
  logic              lookup_hit, accept, insert;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = live_q[g] && (tag_q[g] == req_addr_i);
  end

  assign lookup_hit = |match;
  assign accept     = req_vld_i && !clr_i;
  assign insert     = accept && !lookup_hit;

  always_ff @(posedge clk) begin
    if (insert) tag_q[wr_ptr_q] <= req_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= '0;
      wr_ptr_q  <= '0;
      hit_vld_o <= 1'b0;
      hit_o     <= 1'b0;
      hit_cnt_o <= '0;
      ref_cnt_o <= '0;
    end else begin
      hit_vld_o <= accept;
      hit_o     <= accept && lookup_hit;
      if (clr_i) begin
        live_q    <= '0;
        wr_ptr_q  <= '0;
        hit_cnt_o <= '0;
        ref_cnt_o <= '0;
      end else if (accept) begin
        if (ref_cnt_o != CNT_MAX) ref_cnt_o <= ref_cnt_o + 1'b1;
        if (lookup_hit) begin
          if (hit_cnt_o != CNT_MAX) hit_cnt_o <= hit_cnt_o + 1'b1;
        end else begin
          live_q[wr_ptr_q] <= 1'b1;
          wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
        end
      end
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (live_q == '0 && hit_cnt_o == '0 && ref_cnt_o == '0 && !hit_vld_o)); // R8
  AST_HIT_LE_REF: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt_o <= ref_cnt_o); // R6
  AST_REF_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ref_cnt_o >= $past(ref_cnt_o)); // R7
  AST_REF_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt_o == CNT_MAX && !clr_i) |=> ref_cnt_o == CNT_MAX); // R7
  AST_HIT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld_o && hit_o) |-> wr_ptr_q == $past(wr_ptr_q)); // R5
  AST_MISS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld_o && !hit_o) |-> (wr_ptr_q != $past(wr_ptr_q) || DEPTH == 1)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld_i && !clr_i) |=> (!hit_vld_o && $stable(ref_cnt_o) && $stable(hit_cnt_o))); // R9
endmodule

// File: tb/reuse_fifo_tracker_tb_top.sv
module reuse_fifo_tracker_tb_top;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, rv = 1'b0;
  logic [AW-1:0] ra = '0;
  always #10 clk = ~clk;

  logic        hv [3];
  logic        h  [3];
  logic [31:0] hc [3];
  logic [31:0] rc [3];
  logic [3:0]  hc_n, rc_n;

  reuse_fifo_tracker #(.DEPTH(16), .ADDR_W(AW), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_vld_i(rv), .req_addr_i(ra),
    .hit_vld_o(hv[0]), .hit_o(h[0]), .hit_cnt_o(hc[0]), .ref_cnt_o(rc[0]));
  reuse_fifo_tracker #(.DEPTH(64), .ADDR_W(AW), .CNT_W(32)) dut64_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_vld_i(rv), .req_addr_i(ra),
    .hit_vld_o(hv[1]), .hit_o(h[1]), .hit_cnt_o(hc[1]), .ref_cnt_o(rc[1]));
  reuse_fifo_tracker #(.DEPTH(16), .ADDR_W(AW), .CNT_W(4)) dutsat_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_vld_i(rv), .req_addr_i(ra),
    .hit_vld_o(hv[2]), .hit_o(h[2]), .hit_cnt_o(hc_n), .ref_cnt_o(rc_n));
  assign hc[2] = {28'd0, hc_n};
  assign rc[2] = {28'd0, rc_n};

  int n_chk = 0, n_bad = 0;
  int mq[$];
  int occ[3], e_ref[3], e_hit[3];
  bit e_hv[3], e_h[3];
  int depth_of[3] = '{16, 64, 16};
  int cap_of[3]   = '{32'h7fffffff, 32'h7fffffff, 15};

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input bit v, input int a, input bit c);
    for (int n = 0; n < 3; n++) begin e_hv[n] = 0; e_h[n] = 0; end
    if (c) begin
      mq.delete();
      for (int n = 0; n < 3; n++) begin occ[n] = 0; e_ref[n] = 0; e_hit[n] = 0; end
    end else if (v) begin
      for (int n = 0; n < 3; n++) begin
        bit found = 0;
        foreach (mq[x]) if (mq[x] == n * 65536 + a) found = 1;
        e_hv[n] = 1; e_h[n] = found;
        if (e_ref[n] < cap_of[n] && !(n == 2 && e_ref[n] >= 15)) e_ref[n]++;
        if (found) begin
          if (!(n == 2 && e_hit[n] >= 15)) e_hit[n]++;
        end else begin
          if (occ[n] == depth_of[n]) begin
            for (int x = 0; x < mq.size(); x++)
              if (mq[x] / 65536 == n) begin mq.delete(x); break; end
            occ[n]--;
          end
          mq.push_back(n * 65536 + a);
          occ[n]++;
        end
      end
    end
  endtask

  task automatic step(input bit v, input int a, input bit c, input string ctx);
    @(negedge clk);
    rv = v; ra = AW'(a); clr = c;
    @(posedge clk);
    model(v, a, c);
    #5;
    for (int n = 0; n < 3; n++) begin
      chk($sformatf("R9/%s valid dut%0d", ctx, n), int'(hv[n]), int'(e_hv[n]));
      chk($sformatf("R2/%s hit dut%0d", ctx, n), int'(h[n]), int'(e_h[n]));
      chk($sformatf("%s/%s refcnt dut%0d", n == 2 ? "R7" : "R6", ctx, n), int'(rc[n]), e_ref[n]);
      chk($sformatf("%s/%s hitcnt dut%0d", n == 2 ? "R7" : "R6", ctx, n), int'(hc[n]), e_hit[n]);
    end
  endtask

  task automatic stencil(input string ctx);
    for (int i = 1; i <= 3; i++)
      for (int j = 1; j <= 3; j++)
        for (int k = 1; k <= 3; k++) begin
          step(1, (i-1)*25 + j*5 + k, 0, ctx);
          step(1, (i+1)*25 + j*5 + k, 0, ctx);
          step(1, i*25 + (j-1)*5 + k, 0, ctx);
          step(1, i*25 + (j+1)*5 + k, 0, ctx);
          step(1, i*25 + j*5 + k - 1, 0, ctx);
          step(1, i*25 + j*5 + k + 1, 0, ctx);
        end
  endtask

  bit done = 0;
  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model(0, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 3; n++) begin
      chk("R1 reset valid", int'(hv[n]), 0);
      chk("R1 reset refcnt", int'(rc[n]), 0);
      chk("R1 reset hitcnt", int'(hc[n]), 0);
    end
    step(0, 0, 0, "R1 idle");
    step(1, 7, 0, "R3 first");
    step(1, 7, 0, "R3 back-to-back");
    stencil("R4 stencil");
    repeat (3) step(0, 0, 0, "R9 idle");
    step(1, 31, 1, "R8 clear with request");
    step(1, 31, 0, "R8 after clear");
    stencil("R6 stencil again");
    step(0, 0, 1, "R8 clear");
    for (int a = 100; a < 116; a++) step(1, a, 0, "R4 fill");
    step(1, 100, 0, "R5 hit oldest");
    step(1, 200, 0, "R5 evict hit entry");
    step(1, 100, 0, "R5 evicted despite hit");
    step(1, 101, 0, "R4 next oldest gone");
    step(1, 115, 0, "R4 young stays");
    for (int a = 300; a < 360; a++) step(1, a, 0, "R4 deep fill");
    step(1, 115, 0, "R4 depth split");
    step(0, 0, 0, "R9 tail");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule